// File: doc/BRIEF.md
# Prescaled Countdown Timer

A countdown timer with four word-wide registers on a plain register port: a reload value, the live count, a control word and a sticky expiry flag. While enabled and non-zero, the count drops by one each time a programmable number of base ticks has elapsed. The base tick arrives as a one-cycle enable input, and the prescaler divides it by (divider + 1).

When the count reaches zero, the expiry flag is set. The timer then either refills itself from the reload value and keeps running, or stays at zero. Software clears the flag by writing a one to it. The interrupt output gives a single-cycle pulse only when the flag goes from clear to set.

A register write always wins over counting in the same cycle: the base tick in that cycle is dropped. Register offsets are byte offsets, and only the four word-aligned ones listed below are decoded.

Top module: `prescaled_countdown_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: Register offsets are 0x0 for reload, 0x4 for count, 0x8 for control and 0xC for status. Any other offset reads zero, and a write to it changes nothing.
- R3: Control bit 0 enables counting, bit 1 selects auto-reload, and bits 15:8 hold the divider D. Control reads back exactly these fields, with all other bits zero.
- R4: While the timer is enabled and the count is non-zero, the count drops by one every D+1 base ticks. It does not change while `tick_en` is low.
- R5: Writing the reload register also writes the count and restarts the prescale phase.
- R6: Writing the count register replaces the count and restarts the prescale phase.
- R7: When a step takes the count from 1 to 0, status bit 0 is set. With auto-reload on, the count is refilled from the reload register. With auto-reload off, it stays at 0.
- R8: When the enable bit rises while the count is zero and auto-reload is set in the same write, the count is first fetched from the reload register.
- R9: Reading the count returns zero whenever the timer is disabled. While disabled, the count does not change except by a register write.
- R10: Writing the status register clears exactly the bits written as one. Status bit 0 is the only implemented bit.
- R11: `irq` pulses high for one cycle, in the same cycle that status first reads 1, and only when status rises from 0 to 1.
- R12: With the timer enabled, auto-reload off and the count at zero, nothing counts and no further expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Base tick, one cycle per tick |
| reg_off | input | AW | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for `reg_off`, combinational |
| irq | output | 1 | One-cycle pulse when status rises |

## Verification
Every cycle, the assertions check these properties:
- `irq` coincides exactly with a rise of the status flag.
- A disabled count holds.
- A running count moves by at most one step, or reloads.
- A stopped one-shot count stays at zero.
- Writes to undecoded offsets leave the registers alone.

Only the directed scenarios can show the rest:
- The exact step spacing for a given divider.
- The phase restart after a count write.
- The fetch of the reload value when the timer is enabled.
- Write-one-to-clear status.
- The single interrupt for a flag that stays set.

// File: rtl/prescaled_countdown_timer.sv
module prescaled_countdown_timer #(
  parameter int DW = 32,
  parameter int PW = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] reg_off,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int DLO = 8;

  logic [DW-1:0] load_q, cnt_q;
  logic [PW-1:0] div_q, ps_q;
  logic          en_q, auto_q, stat_q, irq_q;

  logic valid, any_wr, wr_load, wr_cnt, wr_ctl, wr_stat;
  logic running, step, expire, stat_d;

  assign valid   = (reg_off[AW-1:4] == '0) && (reg_off[1:0] == 2'b00);
  assign any_wr  = wr_en && valid;
  assign wr_load = any_wr && reg_off[3:2] == 2'd0;
  assign wr_cnt  = any_wr && reg_off[3:2] == 2'd1;
  assign wr_ctl  = any_wr && reg_off[3:2] == 2'd2;
  assign wr_stat = any_wr && reg_off[3:2] == 2'd3;

  assign running = en_q && (cnt_q != '0);
  assign step    = running && tick_en && !any_wr && (ps_q == div_q);
  assign expire  = step && (cnt_q == DW'(1));
  assign stat_d  = (stat_q & ~(wr_stat & wr_data[0])) | expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      ps_q   <= '0;
      div_q  <= '0;
      en_q   <= 1'b0;
      auto_q <= 1'b0;
    end else if (wr_load) begin
      load_q <= wr_data;
      cnt_q  <= wr_data;
      ps_q   <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wr_data;
      ps_q  <= '0;
    end else if (wr_ctl) begin
      en_q   <= wr_data[0];
      auto_q <= wr_data[1];
      div_q  <= wr_data[DLO +: PW];
      if (!en_q && wr_data[0]) begin
        ps_q <= '0;
        if (cnt_q == '0 && wr_data[1]) cnt_q <= load_q;
      end
    end else if (running && tick_en && !any_wr) begin
      if (step) begin
        ps_q  <= '0;
        cnt_q <= expire ? (auto_q ? load_q : '0) : cnt_q - DW'(1);
      end else begin
        ps_q <= ps_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= stat_d & ~stat_q;
    end
  end

  assign irq = irq_q;

  always_comb begin
    rd_data = '0;
    if (valid) begin
      case (reg_off[3:2])
        2'd0: rd_data = load_q;
        2'd1: rd_data = en_q ? cnt_q : '0;
        2'd2: begin
          rd_data[0]        = en_q;
          rd_data[1]        = auto_q;
          rd_data[DLO +: PW] = div_q;
        end
        default: rd_data[0] = stat_q;
      endcase
    end
  end

  // R11
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $rose(stat_q));
  // R11
  rise_gives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> irq);
  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_en) |=> $stable(cnt_q));
  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wr_en && cnt_q > DW'(1)) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - DW'(1)));
  // R12
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !auto_q && cnt_q == '0 && !wr_en) |=> (cnt_q == '0 && !irq));
  // R2
  bad_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !valid) |=> ($stable(load_q) && $stable(cnt_q) && $stable(en_q)
                           && $stable(auto_q) && $stable(div_q)));
endmodule

// File: tb/test_prescaled_countdown_timer.sv
module test_prescaled_countdown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [11:0] reg_off = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0, bad = 0, irqs = 0;
  bit done = 1'b0;

  prescaled_countdown_timer i_prescaled_countdown_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_off(reg_off),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #2 clk = ~clk;

  always @(negedge clk) if (irq) irqs++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_off = off; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] off, input logic [31:0] exp);
    reg_off = off;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 load", 12'h0, 0);
    rd_chk("R1 count", 12'h4, 0);
    rd_chk("R1 ctrl", 12'h8, 0);
    rd_chk("R1 status", 12'hC, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_offsets;
    wr(12'h0, 32'h55);
    wr(12'h10, 32'h99);
    wr(12'h2, 32'h77);
    rd_chk("R2 load kept", 12'h0, 32'h55);
    rd_chk("R2 unmapped read", 12'h10, 0);
    rd_chk("R3 ctrl unchanged", 12'h8, 0);
    wr(12'h8, 32'hFFFF_A5FC);
    rd_chk("R3 ctrl fields", 12'h8, 32'h0000_A500);
    wr(12'h8, 0);
  endtask

  task automatic t_oneshot;
    int base;
    wr(12'h0, 5);
    rd_chk("R9 disabled reads zero", 12'h4, 0);
    wr(12'h8, 1);
    rd_chk("R5 load wrote count", 12'h4, 5);
    ticks(2);
    rd_chk("R4 two steps", 12'h4, 3);
    base = irqs;
    ticks(3);
    rd_chk("R7 stops at zero", 12'h4, 0);
    rd_chk("R7 status set", 12'hC, 1);
    check("R11 one pulse", irqs - base, 1);
    ticks(4);
    rd_chk("R12 held zero", 12'h4, 0);
    check("R12 no more events", irqs - base, 1);
  endtask

  task automatic t_status;
    wr(12'hC, 0);
    rd_chk("R10 zero write keeps", 12'hC, 1);
    wr(12'hC, 1);
    rd_chk("R10 one write clears", 12'hC, 0);
  endtask

  task automatic t_prescale;
    wr(12'h8, 32'h0000_0201);
    wr(12'h4, 4);
    ticks(5);
    rd_chk("R4 div2 five ticks", 12'h4, 3);
    ticks(1);
    rd_chk("R4 div2 sixth tick", 12'h4, 2);
    repeat (5) @(negedge clk);
    rd_chk("R4 no tick no step", 12'h4, 2);
  endtask

  task automatic t_phase;
    wr(12'h8, 32'h0000_0301);
    wr(12'h4, 10);
    ticks(2);
    wr(12'h4, 10);
    ticks(2);
    rd_chk("R6 phase restarted", 12'h4, 10);
    ticks(2);
    rd_chk("R6 step after restart", 12'h4, 9);
  endtask

  task automatic t_autoreload;
    int base;
    wr(12'h8, 3);
    wr(12'h0, 3);
    base = irqs;
    ticks(3);
    rd_chk("R7 reloaded", 12'h4, 3);
    rd_chk("R7 status set auto", 12'hC, 1);
    check("R11 auto pulse", irqs - base, 1);
    wr(12'hC, 1);
    ticks(3);
    check("R11 second pulse", irqs - base, 2);
    ticks(3);
    rd_chk("R11 status still set", 12'hC, 1);
    check("R11 no pulse while set", irqs - base, 2);
    wr(12'hC, 1);
  endtask

  task automatic t_enable_fetch;
    wr(12'h8, 0);
    wr(12'h4, 7);
    ticks(5);
    rd_chk("R9 disabled read zero", 12'h4, 0);
    wr(12'h8, 1);
    rd_chk("R9 disabled held", 12'h4, 7);
    wr(12'h8, 0);
    wr(12'h4, 0);
    wr(12'h8, 3);
    rd_chk("R8 fetched reload", 12'h4, 3);
    wr(12'h8, 0);
    wr(12'h4, 0);
    wr(12'h8, 1);
    rd_chk("R8 no fetch one-shot", 12'h4, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_offsets();
    t_oneshot();
    t_status();
    t_prescale();
    t_phase();
    t_autoreload();
    t_enable_fetch();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule